// File: doc/BRIEF.md
# Fast Link Pulse Burst Codec

This block carries a 16-bit link code word across a link as a burst of single pulses and turns received bursts back into code words. The burst has 33 evenly spaced slots. Every even slot (counting from zero) holds a framing pulse that is always sent. Each odd slot holds one data bit: a pulse means 1 and no pulse means 0. Bit 0 goes in the slot right after the first framing pulse. All timing comes from cycle counts set by parameters: `HALF_TICKS` cycles between neighbouring slots, and `PERIOD_TICKS` cycles from the start of one burst to the start of the next.

The transmit side takes a code word and an enable. It replaces the five low bits of the word with the standard selector value. It then drives one-cycle strobes on `tx_pulse`, and repeats the burst every period while the enable stays high. The receive side watches a one-cycle pulse-detect strobe. It sorts each pulse into a data window or a framing window, both measured from the last framing pulse. It reports the word with a one-cycle valid flag once all 17 framing pulses have arrived. A burst with a missing framing pulse, or with a pulse that falls outside both windows, gives a one-cycle error flag instead. Pulse shaping, the line interface and the choice of operating mode are handled elsewhere.

Top module: `flp_codec`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_pulse`, `rx_valid` and `rx_err` are 0 and `rx_word` is 0.
- R2: When `tx_en` is sampled high while idle, a burst starts. Slot s (0..32) comes s*HALF_TICKS cycles after the first pulse. Every even slot carries a one-cycle pulse, so a burst holds exactly 17 framing pulses plus its data pulses.
- R3: Odd slot 2k+1 carries a pulse exactly when bit k of the word is 1, so bit 0 is sent first.
- R4: Bits [4:0] of the sent word are always 5'b00001, whatever `tx_word[4:0]` holds. Bits [15:5] come from `tx_word`.
- R5: While `tx_en` stays high, a new burst starts every PERIOD_TICKS cycles, and each burst uses the `tx_word` sampled at its start. Once `tx_en` is low at the end of a period, no further burst starts.
- R6: A received pulse that arrives HALF_TICKS±WIN_TICKS cycles after a framing pulse, with no other data pulse yet in that interval, is taken as a 1 for that bit. If no such pulse arrives, the bit is 0.
- R7: While a burst is being collected, a pulse that arrives 2*HALF_TICKS±WIN_TICKS cycles after the last framing pulse is taken as the next framing pulse. Later windows are measured from its actual arrival. When the receiver is hunting, the first pulse it sees is taken as framing pulse 1.
- R8: One cycle after the 17th framing pulse is sampled, `rx_valid` is high and `rx_word` holds the decoded word.
- R9: If no pulse arrives within 2*HALF_TICKS+WIN_TICKS cycles of the last framing pulse, the burst is dropped. `rx_err` is raised and no `rx_valid` follows for that burst.
- R10: A pulse outside both windows, or a second pulse in one data window, drops the burst and raises `rx_err`.
- R11: After an error, the receiver ignores pulses until it has seen 2*HALF_TICKS+WIN_TICKS cycles of silence. It then hunts for a new burst, so a bad burst gives exactly one error.
- R12: `rx_valid` and `rx_err` each last one cycle and are never high together. `rx_word` changes only in a cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Start bursts and keep repeating them |
| tx_word | input | 16 | Code word to send; bits [4:0] are overridden |
| tx_pulse | output | 1 | One-cycle strobe for each sent pulse |
| rx_det | input | 1 | One-cycle strobe for each detected pulse |
| rx_word | output | 16 | Last word decoded without error |
| rx_valid | output | 1 | One-cycle flag: `rx_word` has just been updated |
| rx_err | output | 1 | One-cycle flag: a burst was dropped |

## Verification
The assertions check these properties on every cycle:
- each transmit pulse falls on a slot, every framing slot carries a pulse, and no two slots are adjacent;
- every valid flag follows an accepted framing pulse, and every error flag follows a detected violation;
- the valid and error flags each last one cycle, never occur together, and the word holds between valid flags.

Some behaviour only the bench scenarios can show:
- the data bit carried in each slot, the override of the selector bits, and the repeat interval, word latching and stopping of bursts;
- the exact edges of both windows: jitter up to the window limit is accepted and one cycle beyond it is not;
- the single error for a burst that keeps sending pulses after its fault.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int CW_W    = 16;
  localparam int N_SLOTS = 33;
  localparam int N_CLK   = 17;
  localparam logic [4:0] SELECTOR = 5'b00001;

  // Overlay the fixed selector field onto the low bits of a word.
  function automatic logic [CW_W-1:0] with_selector(input logic [CW_W-1:0] w);
    return {w[CW_W-1:5], SELECTOR};
  endfunction

  // True when elapsed count e lies within centre +/- win.
  function automatic logic in_window(input int unsigned e,
                                     input int unsigned centre,
                                     input int unsigned win);
    return ((e + win) >= centre) && (e <= (centre + win));
  endfunction

  // Even slot indices hold framing pulses.
  function automatic logic slot_is_clock(input logic [5:0] idx);
    return !idx[0];
  endfunction
endpackage

// File: rtl/flp_tx.sv
module flp_tx
  import flp_pkg::*;
#(
  parameter int HALF_TICKS   = 1563,
  parameter int PERIOD_TICKS = 400000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CW_W-1:0] word,
  output logic            pulse,
  output logic            slot_evt,
  output logic [5:0]      slot_idx
);
  localparam int PW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int TW = $clog2(PERIOD_TICKS);
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_TICKS - 1);
  localparam logic [TW-1:0] T_LAST  = TW'(PERIOD_TICKS - 1);

  logic            active;
  logic [CW_W-1:0] word_q;
  logic [TW-1:0]   t_cnt;
  logic [PW-1:0]   ph;
  logic [5:0]      pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      word_q <= '0;
      t_cnt  <= '0;
      ph     <= '0;
      pos    <= '0;
    end else if (!active) begin
      if (en) begin
        active <= 1'b1;
        word_q <= with_selector(word);
        t_cnt  <= '0;
        ph     <= '0;
        pos    <= '0;
      end
    end else if (t_cnt == T_LAST) begin
      if (en) begin
        word_q <= with_selector(word);
        t_cnt  <= '0;
        ph     <= '0;
        pos    <= '0;
      end else begin
        active <= 1'b0;
      end
    end else begin
      t_cnt <= t_cnt + 1'b1;
      if (ph == PH_LAST) begin
        ph <= '0;
        if (pos != 6'(N_SLOTS)) pos <= pos + 1'b1;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  assign slot_evt = active && (ph == '0) && (pos < 6'(N_SLOTS));
  assign slot_idx = pos;
  assign pulse    = slot_evt && (slot_is_clock(pos) || word_q[pos[4:1]]);
endmodule

// File: rtl/flp_rx.sv
module flp_rx
  import flp_pkg::*;
#(
  parameter int HALF_TICKS = 1563,
  parameter int WIN_TICKS  = 300
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            det,
  output logic [CW_W-1:0] word,
  output logic            valid,
  output logic            err,
  output logic            clk_acc,
  output logic            data_acc,
  output logic            bad_evt
);
  localparam int LIM = 2 * HALF_TICKS + WIN_TICKS;
  localparam int EW  = $clog2(LIM + 2) + 1;

  typedef enum logic [1:0] {S_HUNT, S_COLLECT, S_QUIET} rx_state_t;

  rx_state_t       st;
  logic [EW-1:0]   e;
  logic [4:0]      cnt;
  logic            dseen;
  logic [CW_W-2:0] work;

  logic in_d, in_c, late, collecting;

  assign collecting = (st == S_COLLECT);
  assign in_d       = in_window(32'(e), HALF_TICKS, WIN_TICKS);
  assign in_c       = in_window(32'(e), 2 * HALF_TICKS, WIN_TICKS);
  assign late       = 32'(e) > LIM;

  assign clk_acc  = det && ((st == S_HUNT) || (collecting && in_c));
  assign data_acc = collecting && det && in_d && !dseen;
  assign bad_evt  = collecting && (det ? !(in_c || (in_d && !dseen)) : late);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HUNT;
      e     <= '0;
      cnt   <= '0;
      dseen <= 1'b0;
      work  <= '0;
      word  <= '0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else begin
      valid <= 1'b0;
      err   <= 1'b0;
      unique case (st)
        S_HUNT: begin
          if (det) begin
            st    <= S_COLLECT;
            cnt   <= 5'd1;
            e     <= EW'(1);
            dseen <= 1'b0;
          end
        end
        S_COLLECT: begin
          if (bad_evt) begin
            err <= 1'b1;
            st  <= S_QUIET;
            e   <= EW'(1);
          end else if (clk_acc) begin
            if (cnt == 5'(N_CLK - 1)) begin
              word  <= {dseen, work};
              valid <= 1'b1;
              st    <= S_HUNT;
            end else begin
              work[4'(cnt - 5'd1)] <= dseen;
              cnt <= cnt + 1'b1;
            end
            e     <= EW'(1);
            dseen <= 1'b0;
          end else begin
            if (data_acc) dseen <= 1'b1;
            e <= e + 1'b1;
          end
        end
        S_QUIET: begin
          if (det)       e  <= EW'(1);
          else if (late) st <= S_HUNT;
          else           e  <= e + 1'b1;
        end
        default: st <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/flp_codec.sv
module flp_codec
  import flp_pkg::*;
#(
  parameter int HALF_TICKS   = 1563,
  parameter int PERIOD_TICKS = 400000,
  parameter int WIN_TICKS    = 300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic [15:0] tx_word,
  output logic        tx_pulse,
  input  logic        rx_det,
  output logic [15:0] rx_word,
  output logic        rx_valid,
  output logic        rx_err
);
  logic       tx_slot_evt;
  logic [5:0] tx_slot_idx;
  logic       rx_clk_acc;
  logic       rx_data_acc;
  logic       rx_bad_evt;

  flp_tx #(
    .HALF_TICKS  (HALF_TICKS),
    .PERIOD_TICKS(PERIOD_TICKS)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tx_en),
    .word    (tx_word),
    .pulse   (tx_pulse),
    .slot_evt(tx_slot_evt),
    .slot_idx(tx_slot_idx)
  );

  flp_rx #(
    .HALF_TICKS(HALF_TICKS),
    .WIN_TICKS (WIN_TICKS)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .det     (rx_det),
    .word    (rx_word),
    .valid   (rx_valid),
    .err     (rx_err),
    .clk_acc (rx_clk_acc),
    .data_acc(rx_data_acc),
    .bad_evt (rx_bad_evt)
  );
endmodule

// File: rtl/flp_codec_chk.sv
module flp_codec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_pulse,
  input logic        slot_evt,
  input logic [5:0]  slot_idx,
  input logic        rx_valid,
  input logic        rx_err,
  input logic [15:0] rx_word,
  input logic        clk_acc,
  input logic        bad_evt
);
  a_r2_pulse_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pulse |-> slot_evt);

  a_r2_clock_always: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt && !slot_idx[0]) |-> tx_pulse);

  a_r2_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    slot_evt |=> !slot_evt);

  a_r8_valid_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(clk_acc));

  a_r9_err_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> $past(bad_evt));

  a_r12_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r12_single_err: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> !rx_err);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err));

  a_r12_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_word));
endmodule

bind flp_codec flp_codec_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_pulse(tx_pulse),
  .slot_evt(tx_slot_evt),
  .slot_idx(tx_slot_idx),
  .rx_valid(rx_valid),
  .rx_err  (rx_err),
  .rx_word (rx_word),
  .clk_acc (rx_clk_acc),
  .bad_evt (rx_bad_evt)
);

// File: tb/flp_codec_tb.sv
module flp_codec_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int P = 300;
  localparam int W = 2;
  localparam int LIM = 2 * H + W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0;
  logic [15:0] tx_word = '0;
  logic        tx_pulse;
  logic        loop = 1'b0;
  logic        man_det = 1'b0;
  logic        rx_det;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic        rx_err;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  int pn = 0;
  int ptimes[0:127];
  int nval = 0;
  int nerr = 0;
  logic [15:0] wq[0:3];
  bit done = 0;

  assign rx_det = loop ? tx_pulse : man_det;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flp_codec #(.HALF_TICKS(H), .PERIOD_TICKS(P), .WIN_TICKS(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_word(tx_word),
    .tx_pulse(tx_pulse), .rx_det(rx_det), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_err(rx_err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_pulse && pn < 128) begin
      ptimes[pn] = cyc;
      pn = pn + 1;
    end
    if (rx_valid) begin
      if (nval < 4) wq[nval] = rx_word;
      nval = nval + 1;
    end
    if (rx_err) nerr = nerr + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    #1;
    pn = 0;
    nval = 0;
    nerr = 0;
  endtask

  function automatic logic [15:0] fsel(input logic [15:0] w);
    return {w[15:5], 5'b00001};
  endfunction

  function automatic int n_pulses(input logic [15:0] w);
    int n = 17;
    for (int k = 0; k < 16; k++) n += w[k];
    return n;
  endfunction

  // Check pulse i..i+cnt-1 against the burst pattern of w starting at base.
  function automatic int pattern_miss(input logic [15:0] w, input int first);
    int idx = first;
    int miss = 0;
    for (int s = 0; s < 33; s++) begin
      if ((s % 2 == 0) || w[s / 2]) begin
        if (ptimes[idx] - ptimes[first] != s * H) miss++;
        idx++;
      end
    end
    return miss;
  endfunction

  task automatic tx_once(input logic [15:0] w, input string tag);
    logic [15:0] f;
    f = fsel(w);
    clear_mon();
    loop = 1'b1;
    @(negedge clk);
    tx_word = w;
    tx_en = 1'b1;
    @(negedge clk);
    tx_en = 1'b0;
    repeat (P + 20) @(negedge clk);
    chk(pn == n_pulses(f), {tag, " R2 R3 pulse count"}, pn, n_pulses(f));
    if (pn == n_pulses(f))
      chk(pattern_miss(f, 0) == 0, {tag, " R2 R3 slot timing"}, pattern_miss(f, 0), 0);
    chk(nval == 1 && nerr == 0, {tag, " R8 R12 one valid"}, nval * 100 + nerr, 100);
    chk(wq[0] == f, {tag, " R4 R6 R8 word"}, int'(wq[0]), int'(f));
    loop = 1'b0;
  endtask

  task automatic man_burst(input logic [32:0] present, input int jpos, input int jit,
                           input int extra);
    int t;
    for (int c = 0; c <= 32 * H + W + 2; c++) begin
      @(negedge clk);
      man_det = 1'b0;
      for (int s = 0; s < 33; s++) begin
        t = s * H + ((s == jpos) ? jit : 0);
        if (present[s] && c == t) man_det = 1'b1;
      end
      if (c == extra) man_det = 1'b1;
    end
    @(negedge clk);
    man_det = 1'b0;
    repeat (LIM + 20) @(negedge clk);
  endtask

  function automatic logic [32:0] mk(input logic [15:0] w);
    logic [32:0] p;
    for (int s = 0; s < 33; s++) p[s] = (s % 2 == 0) ? 1'b1 : w[s / 2];
    return p;
  endfunction

  task automatic rx_case(input logic [32:0] pres, input int jpos, input int jit,
                         input int extra, input bit good, input logic [15:0] w,
                         input string tag);
    clear_mon();
    man_burst(pres, jpos, jit, extra);
    if (good) begin
      chk(nval == 1 && nerr == 0, {tag, " valid count"}, nval * 100 + nerr, 100);
      chk(wq[0] == w, {tag, " word"}, int'(wq[0]), int'(w));
    end else begin
      chk(nval == 0 && nerr == 1, {tag, " single error"}, nval * 100 + nerr, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w1, w2;
    int c1;
    repeat (3) @(negedge clk);
    chk(tx_pulse == 0 && rx_valid == 0 && rx_err == 0 && rx_word == 0,
        "R1 reset outputs", int'({tx_pulse, rx_valid, rx_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_pulse == 0 && rx_valid == 0 && rx_err == 0 && rx_word == 0,
        "R1 after release", int'({tx_pulse, rx_valid, rx_err}), 0);

    // Transmit sweep in loopback: single bits, extremes, scrambled words.
    for (int k = 5; k < 16; k++) tx_once(16'(1 << k), "sweep single");
    tx_once(16'hFFFF, "sweep ones");
    tx_once(16'h0000, "sweep zeros");
    tx_once(16'hAAAA, "sweep alt A");
    tx_once(16'h5555, "sweep alt 5");
    for (int i = 1; i <= 16; i++) tx_once(16'(i * 16'h9E37), "sweep mixed");
    tx_once(16'h801E, "R4 selector override");

    // R5: repeat while enabled, word latched per burst, stop after disable.
    w1 = 16'hC3A0;
    w2 = 16'h3C40;
    clear_mon();
    loop = 1'b1;
    @(negedge clk);
    tx_word = w1;
    tx_en = 1'b1;
    repeat (10) @(negedge clk);
    tx_word = w2;
    repeat (P) @(negedge clk);
    tx_en = 1'b0;
    repeat (2 * P + 20) @(negedge clk);
    c1 = n_pulses(fsel(w1));
    chk(pn == c1 + n_pulses(fsel(w2)), "R5 two bursts then stop", pn, c1 + n_pulses(fsel(w2)));
    if (pn > c1)
      chk(ptimes[c1] - ptimes[0] == P, "R5 burst interval", ptimes[c1] - ptimes[0], P);
    chk(nval == 2, "R5 two words", nval, 2);
    chk(wq[0] == fsel(w1), "R5 first word latched", int'(wq[0]), int'(fsel(w1)));
    chk(wq[1] == fsel(w2), "R5 second word", int'(wq[1]), int'(fsel(w2)));
    loop = 1'b0;

    // Receive-only cases with hand-built bursts.
    rx_case(mk(16'h1234), -1, 0, -1, 1, 16'h1234, "R7 R8 clean manual");
    rx_case(mk(16'hFFFF), 7, W, -1, 1, 16'hFFFF, "R6 data late edge");
    rx_case(mk(16'hFFFF), 7, -W, -1, 1, 16'hFFFF, "R6 data early edge");
    rx_case(mk(16'h0F0F), 10, W, -1, 1, 16'h0F0F, "R7 clock late edge");
    rx_case(mk(16'hF0F0), 20, -W, -1, 1, 16'hF0F0, "R7 clock early edge");
    rx_case(mk(16'hFFFF), 7, W + 1, -1, 0, 16'h0, "R10 data beyond window");
    rx_case(mk(16'hFFFF) & ~(33'd1 << 12), -1, 0, -1, 0, 16'h0, "R9 missing clock");
    rx_case(mk(16'h0000), -1, 0, 4 * H + 4, 0, 16'h0, "R10 R11 stray pulse");
    rx_case(mk(16'hFFFF), -1, 0, 3 * H + 1, 0, 16'h0, "R10 double data");
    rx_case(mk(16'hFFFF) & 33'h0FFFF, -1, 0, -1, 0, 16'h0, "R9 truncated burst");
    rx_case(mk(16'hBEEF), -1, 0, -1, 1, 16'hBEEF, "R11 recovery after errors");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule